// File: doc/BRIEF.md
# Credit-Flow Chip Link Adapter

This block carries a valid/ready message stream across a chip boundary without a ready wire going back. The transmit half keeps a credit count that starts at the depth of the receive buffer. It spends one credit for each message it launches, and it gets one credit back for each token the receive half returns. The receive half stores arriving messages in a small buffer and offers them to its consumer as valid/ready. Each time the consumer takes a message, the receive half sends one token back. The adapter therefore turns valid/ready into credit flow on one side and turns it back into valid/ready on the other.

The transmit half also makes the slower forwarded link clock. A divider produces it, and the division factor can be changed at run time to any even value from 2 to 256. The transmit half also produces a link reset that acts as a start signal. This reset is released only after the forwarded clock has been running for a set number of rising edges, so the receive input side always sees a clock while it is held in reset. In this model all link-side transfers happen on the rising edges of the forwarded clock. The rising edge is represented in the core clock domain by a one-cycle launch slot. A status bit flags a possible deadlock when no credit has been available for longer than a programmable number of link cycles.

Top module: `credit_link`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `credit_o` equals DEPTH, `link_rst_o` is 1, `link_clk_o` is 0, and `in_rdy`, `out_val` and `deadlock_o` are 0.
- R2: `link_clk_o` has a period of 2*(`div_cfg`+1) core cycles and is high for `div_cfg`+1 of them. So `div_cfg` values 0 to 127 give division factors 2 to 256.
- R3: After reset, `link_rst_o` stays high through the first RST_EDGES (default 4) rising edges of `link_clk_o`. It falls on the same core edge as the next rising edge.
- R4: `in_rdy` is high only in the core cycle just before a rising edge of `link_clk_o`, and only when the credit count is nonzero and `link_rst_o` is low. At most one message is accepted per link cycle.
- R5: Each accepted message lowers `credit_o` by one. When `credit_o` is 0, no message is accepted, so exactly DEPTH messages are accepted when nothing is dequeued. `credit_o` never exceeds DEPTH.
- R6: Messages leave on `out_msg` in the order they were accepted and with unchanged values. A message accepted at one rising link edge is shown on `out_val`/`out_msg` just after the next rising link edge.
- R7: A dequeue (`out_val` and `out_rdy` high at a core edge) raises `credit_o` by one just after the second rising link edge that follows it, and not earlier. A credit return and a send in the same link cycle leave `credit_o` unchanged.
- R8: With `credit_o` at 0, `deadlock_o` is set at the (`dl_limit`+1)-th rising link edge after the count reached 0. It clears one core cycle after `credit_o` becomes nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock of the transmit chip |
| rst | input | 1 | Synchronous active-high reset |
| div_cfg | input | 7 | Half-period minus one; division factor is 2*(div_cfg+1) |
| dl_limit | input | 8 | Link cycles at zero credit tolerated before deadlock is flagged |
| in_val | input | 1 | Upstream message valid |
| in_msg | input | 16 | Upstream message |
| in_rdy | output | 1 | Upstream ready (launch slot with credit available) |
| out_val | output | 1 | Downstream message valid |
| out_msg | output | 16 | Downstream message (head of the receive buffer) |
| out_rdy | input | 1 | Downstream ready |
| link_clk_o | output | 1 | Forwarded link clock |
| link_rst_o | output | 1 | Link start reset, high until the link clock has run |
| credit_o | output | 3 | Current credit count (0 to DEPTH) |
| deadlock_o | output | 1 | Credit starvation flag |

## Verification
Every result is tied to the rising edges of the forwarded clock rather than to a fixed number of core cycles. An accepted message is due at the first link rise after its acceptance. A returned credit is due at the second link rise after the dequeue. The deadlock flag is due at rise `dl_limit`+1 after starvation begins, and the link reset falls at rise RST_EDGES+1. The bench samples every output on the falling core edge and detects a link rise by comparing two successive samples of `link_clk_o`. Each check counts these observed rises and checks the output at the rise where the result is due and at the rise just before it.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;

    // Message payload width carried across the link.
    localparam int MSG_W = 16;
    // Width of the half-period configuration (factors 2..256).
    localparam int DIV_W = 7;

    typedef logic [MSG_W-1:0] msg_t;

    // One link beat as launched by the transmit half.
    typedef struct packed {
        logic vld;
        msg_t data;
    } beat_t;

    // Link start reset sequencing.
    typedef enum logic [1:0] {
        LR_HOLD = 2'd0,
        LR_RUN  = 2'd1
    } lrst_state_e;

    // Credit count update from the two link-cycle events.
    function automatic logic [1:0] credit_delta_sel(input logic ret, input logic send);
        return {ret, send};
    endfunction

endpackage

// File: rtl/clink_clkgen.sv
module clink_clkgen
    import credit_link_pkg::*;
#(
    parameter int RST_EDGES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             link_clk,
    output logic             launch,
    output logic             link_rst
);

    localparam int EDGE_W = $clog2(RST_EDGES + 1);

    logic [DIV_W-1:0]  div_cnt_q;
    logic              lclk_q;
    logic              term;
    logic [EDGE_W-1:0] edges_q;
    lrst_state_e       st_q;

    // Terminal count of the half period; >= tolerates a lowered div_cfg.
    assign term   = (div_cnt_q >= div_cfg);
    // Core cycle whose closing edge is a rising edge of the link clock.
    assign launch = term && !lclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt_q <= '0;
            lclk_q    <= 1'b0;
        end else if (term) begin
            div_cnt_q <= '0;
            lclk_q    <= ~lclk_q;
        end else begin
            div_cnt_q <= div_cnt_q + DIV_W'(1);
        end
    end

    // Start reset: count RST_EDGES rising edges, release on the next one.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= LR_HOLD;
            edges_q <= '0;
        end else if (launch && st_q == LR_HOLD) begin
            if (edges_q == EDGE_W'(RST_EDGES)) begin
                st_q <= LR_RUN;
            end else begin
                edges_q <= edges_q + EDGE_W'(1);
            end
        end
    end

    assign link_clk = lclk_q;
    assign link_rst = (st_q == LR_HOLD);

endmodule

// File: rtl/clink_sender.sv
module clink_sender
    import credit_link_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DL_W  = 8,
    localparam int CRD_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            link_rst,
    input  logic            launch,
    input  logic [DL_W-1:0] dl_limit,
    input  logic            in_val,
    input  msg_t            in_msg,
    output logic            in_rdy,
    input  logic            credit_tok,
    output beat_t           beat,
    output logic [CRD_W-1:0] credit,
    output logic            deadlock
);

    logic [CRD_W-1:0] credit_q;
    logic [DL_W-1:0]  zcnt_q;
    logic             dead_q;
    beat_t            beat_q;
    logic             send;
    logic             ret;
    logic             hold;

    assign hold   = rst || link_rst;
    assign in_rdy = launch && !link_rst && (credit_q != '0);
    assign send   = in_val && in_rdy;
    assign ret    = launch && credit_tok;

    always_ff @(posedge clk) begin
        if (hold) begin
            credit_q <= CRD_W'(DEPTH);
        end else begin
            unique case (credit_delta_sel(ret, send))
                2'b10:   credit_q <= credit_q + CRD_W'(1);
                2'b01:   credit_q <= credit_q - CRD_W'(1);
                default: credit_q <= credit_q;
            endcase
        end
    end

    // Launch register: one beat per link cycle, held for the whole cycle.
    always_ff @(posedge clk) begin
        if (hold) begin
            beat_q <= '0;
        end else if (launch) begin
            beat_q.vld <= send;
            if (send) begin
                beat_q.data <= in_msg;
            end
        end
    end

    // Starvation watch in link cycles.
    always_ff @(posedge clk) begin
        if (hold) begin
            zcnt_q <= '0;
            dead_q <= 1'b0;
        end else if (credit_q != '0) begin
            zcnt_q <= '0;
            dead_q <= 1'b0;
        end else if (launch) begin
            if (zcnt_q == dl_limit) begin
                dead_q <= 1'b1;
            end
            if (zcnt_q != '1) begin
                zcnt_q <= zcnt_q + DL_W'(1);
            end
        end
    end

    assign beat     = beat_q;
    assign credit   = credit_q;
    assign deadlock = dead_q;

endmodule

// File: rtl/clink_receiver.sv
module clink_receiver
    import credit_link_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_rst,
    input  logic             launch,
    input  beat_t            beat,
    output logic             out_val,
    output msg_t             out_msg,
    input  logic             out_rdy,
    output logic             credit_tok,
    output logic [CNT_W-1:0] fill
);

    msg_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
    logic [CNT_W-1:0] cnt_q, pend_q;
    logic             tok_q;
    logic             wr, rd, tok_send, hold;

    assign hold     = rst || link_rst;
    assign wr       = launch && beat.vld;
    assign rd       = out_val && out_rdy;
    assign tok_send = launch && (pend_q != '0);

    // Pointer wrap: free for power-of-two depths, compare otherwise.
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
        assign wr_nxt = wr_ptr_q + PTR_W'(1);
        assign rd_nxt = rd_ptr_q + PTR_W'(1);
    end else begin : g_wrap_cmp
        assign wr_nxt = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
        assign rd_nxt = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[wr_ptr_q] <= beat.data;
        end
    end

    always_ff @(posedge clk) begin
        if (hold) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (wr) wr_ptr_q <= wr_nxt;
            if (rd) rd_ptr_q <= rd_nxt;
            cnt_q <= cnt_q + CNT_W'(wr) - CNT_W'(rd);
        end
    end

    // Tokens owed to the transmit half, returned one per link cycle.
    always_ff @(posedge clk) begin
        if (hold) begin
            pend_q <= '0;
            tok_q  <= 1'b0;
        end else begin
            pend_q <= pend_q + CNT_W'(rd) - CNT_W'(tok_send);
            if (launch) begin
                tok_q <= (pend_q != '0);
            end
        end
    end

    assign out_val    = (cnt_q != '0);
    assign out_msg    = mem[rd_ptr_q];
    assign credit_tok = tok_q;
    assign fill       = cnt_q;

endmodule

// File: rtl/credit_link.sv
module credit_link
    import credit_link_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int RST_EDGES = 4,
    parameter int DL_W      = 8,
    localparam int CRD_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [DL_W-1:0]  dl_limit,
    input  logic             in_val,
    input  logic [MSG_W-1:0] in_msg,
    output logic             in_rdy,
    output logic             out_val,
    output logic [MSG_W-1:0] out_msg,
    input  logic             out_rdy,
    output logic             link_clk_o,
    output logic             link_rst_o,
    output logic [CRD_W-1:0] credit_o,
    output logic             deadlock_o
);

    logic             launch;
    logic             link_rst;
    logic             link_clk;
    logic             credit_tok;
    beat_t            beat;
    logic [CRD_W-1:0] rx_fill;

    clink_clkgen #(.RST_EDGES(RST_EDGES)) clkgen_i (
        .clk      (clk),
        .rst      (rst),
        .div_cfg  (div_cfg),
        .link_clk (link_clk),
        .launch   (launch),
        .link_rst (link_rst)
    );

    clink_sender #(.DEPTH(DEPTH), .DL_W(DL_W)) tx_i (
        .clk        (clk),
        .rst        (rst),
        .link_rst   (link_rst),
        .launch     (launch),
        .dl_limit   (dl_limit),
        .in_val     (in_val),
        .in_msg     (in_msg),
        .in_rdy     (in_rdy),
        .credit_tok (credit_tok),
        .beat       (beat),
        .credit     (credit_o),
        .deadlock   (deadlock_o)
    );

    clink_receiver #(.DEPTH(DEPTH)) rx_i (
        .clk        (clk),
        .rst        (rst),
        .link_rst   (link_rst),
        .launch     (launch),
        .beat       (beat),
        .out_val    (out_val),
        .out_msg    (out_msg),
        .out_rdy    (out_rdy),
        .credit_tok (credit_tok),
        .fill       (rx_fill)
    );

    assign link_clk_o = link_clk;
    assign link_rst_o = link_rst;

endmodule

// File: rtl/credit_link_chk.sv
module credit_link_chk #(
    parameter int DEPTH = 4,
    localparam int CRD_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             launch,
    input logic             link_clk,
    input logic             link_rst,
    input logic             in_val,
    input logic             in_rdy,
    input logic             out_val,
    input logic             tok,
    input logic             rx_wr,
    input logic [CRD_W-1:0] rx_fill,
    input logic [CRD_W-1:0] credit,
    input logic             deadlock
);

    // R1: reset state
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (link_rst && !link_clk && credit == CRD_W'(DEPTH) && !deadlock && !out_val));

    // R2: a launch slot is followed by a link clock rise
    p_launch_rise_r2: assert property (@(posedge clk) disable iff (rst)
        launch |=> $rose(link_clk));

    // R2: the link clock rises only after a launch slot
    p_rise_from_launch_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(link_clk) |-> $past(launch));

    // R3: the start reset is released only together with a link clock rise
    p_rst_release_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(link_rst) |-> $rose(link_clk));

    // R4: ready only in a launch slot of a running link
    p_rdy_slot_r4: assert property (@(posedge clk) disable iff (rst)
        in_rdy |-> (launch && !link_rst));

    // R5: credit never exceeds the buffer depth
    p_credit_bound_r5: assert property (@(posedge clk) disable iff (rst)
        credit <= CRD_W'(DEPTH));

    // R5: an arriving beat always finds room in the receive buffer
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        rx_wr |-> (rx_fill < CRD_W'(DEPTH)));

    // R7: per link cycle, credit moves by returns minus sends
    p_credit_step_r7: assert property (@(posedge clk) disable iff (rst)
        (launch && !link_rst) |=>
            (int'(credit) == int'($past(credit)) + int'($past(tok)) - int'($past(in_val && in_rdy))));

    // R7: credit is stable between launch slots
    p_credit_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !launch |=> $stable(credit));

    // R8: nonzero credit clears the deadlock flag
    p_dead_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (credit != '0) |=> !deadlock);

    // R8: the flag is raised only in a starved launch slot
    p_dead_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(deadlock) |-> ($past(credit) == '0 && $past(launch)));

endmodule

bind credit_link credit_link_chk #(.DEPTH(DEPTH)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .link_clk (link_clk),
    .link_rst (link_rst),
    .in_val   (in_val),
    .in_rdy   (in_rdy),
    .out_val  (out_val),
    .tok      (credit_tok),
    .rx_wr    (launch && beat.vld),
    .rx_fill  (rx_fill),
    .credit   (credit_o),
    .deadlock (deadlock_o)
);

// File: tb/credit_link_tb_top.sv
module credit_link_tb_top;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  div_cfg = '0;
    logic [7:0]  dl_limit = '0;
    logic        in_val = 1'b0;
    logic [15:0] in_msg = '0;
    logic        in_rdy;
    logic        out_val;
    logic [15:0] out_msg;
    logic        out_rdy = 1'b0;
    logic        link_clk_o;
    logic        link_rst_o;
    logic [2:0]  credit_o;
    logic        deadlock_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit lc_now = 1'b0;
    bit rose   = 1'b0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    credit_link dut_i (
        .clk(clk), .rst(rst), .div_cfg(div_cfg), .dl_limit(dl_limit),
        .in_val(in_val), .in_msg(in_msg), .in_rdy(in_rdy),
        .out_val(out_val), .out_msg(out_msg), .out_rdy(out_rdy),
        .link_clk_o(link_clk_o), .link_rst_o(link_rst_o),
        .credit_o(credit_o), .deadlock_o(deadlock_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance to the next falling edge and note a link clock rise.
    task automatic step();
        bit prev;
        prev = lc_now;
        @(negedge clk);
        lc_now = link_clk_o;
        rose = !prev && lc_now;
    endtask

    task automatic do_reset(input int cfg, input int lim);
        rst = 1'b1; in_val = 1'b0; out_rdy = 1'b0;
        div_cfg = 7'(cfg); dl_limit = 8'(lim);
        exp_q.delete();
        repeat (3) step();
        rst = 1'b0;
        lc_now = link_clk_o;
    endtask

    task automatic wait_up();
        while (link_rst_o) step();
    endtask

    // Push messages with the consumer stalled for a number of falling edges.
    task automatic fill(input int steps, output int acc);
        bit hs;
        acc = 0;
        in_val = 1'b1;
        for (int i = 0; i < steps; i++) begin
            hs = in_val && in_rdy;
            if (hs) begin exp_q.push_back(in_msg); acc++; end
            step();
            if (hs) in_msg = in_msg + 16'd1;
        end
        in_val = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset(0, 0);
        chk("R1", "credit after reset", credit_o, DEPTH);
        chk("R1", "link_rst after reset", link_rst_o, 1);
        chk("R1", "link_clk/in_rdy/out_val/deadlock after reset",
            {link_clk_o, in_rdy, out_val, deadlock_o}, 0);
    endtask

    task automatic t_period(input int cfg);
        int n, hi;
        do_reset(cfg, 0);
        do step(); while (!rose);
        n = 0; hi = 0;
        do begin step(); n++; if (lc_now) hi++; end while (!rose);
        chk("R2", $sformatf("period cfg=%0d", cfg), n, 2 * (cfg + 1));
        chk("R2", $sformatf("high time cfg=%0d", cfg), hi, cfg + 1);
    endtask

    task automatic t_link_reset();
        int k, at4, at5;
        do_reset(1, 0);
        k = 0; at4 = -1; at5 = -1;
        while (k < 5) begin
            step();
            if (rose) begin
                k++;
                if (k == 4) at4 = link_rst_o;
                if (k == 5) at5 = link_rst_o;
            end
        end
        chk("R3", "link_rst after 4th rise", at4, 1);
        chk("R3", "link_rst after 5th rise", at5, 0);
    endtask

    task automatic t_fill_and_return();
        int acc, k, c1, c2;
        do_reset(1, 0);
        wait_up();
        in_msg = 16'h1000;
        fill(60, acc);
        chk("R5", "messages accepted without dequeue", acc, DEPTH);
        chk("R5", "credit when exhausted", credit_o, 0);
        // R7: single dequeue, credit visible at second following rise
        out_rdy = 1'b1;
        step();
        out_rdy = 1'b0;
        void'(exp_q.pop_front());
        k = 0; c1 = -1; c2 = -1;
        while (k < 2) begin
            step();
            if (rose) begin
                k++;
                if (k == 1) c1 = credit_o;
                if (k == 2) c2 = credit_o;
            end
        end
        chk("R7", "credit at first rise after dequeue", c1, 0);
        chk("R7", "credit at second rise after dequeue", c2, 1);
    endtask

    task automatic t_drain();
        int bad;
        bad = 0;
        out_rdy = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (out_val) begin
                if (exp_q.size() == 0 || out_msg != exp_q[0]) bad++;
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
            step();
        end
        out_rdy = 1'b0;
        chk("R6", "order/value mismatches on drain", bad, 0);
        chk("R6", "messages left undelivered", exp_q.size(), 0);
        chk("R7", "credit after full drain", credit_o, DEPTH);
    endtask

    task automatic t_latency();
        int k, early, v1, m1;
        do_reset(2, 0);
        wait_up();
        in_msg = 16'hBEEF;
        in_val = 1'b1;
        while (!in_rdy) step();
        step();
        in_val = 1'b0;
        early = 0; k = 0; v1 = -1; m1 = -1;
        if (out_val) early++;
        while (k < 1) begin
            step();
            if (rose) begin k++; v1 = out_val; m1 = out_msg; end
            else if (out_val) early++;
        end
        chk("R6", "out_val before next link rise", early, 0);
        chk("R6", "out_val at next link rise", v1, 1);
        chk("R6", "out_msg at next link rise", m1, 16'hBEEF);
    endtask

    task automatic t_stream();
        bit hs, rx, need_rise;
        int bad, over, slot, sent;
        do_reset(0, 0);
        wait_up();
        in_msg = 16'h2000;
        bad = 0; over = 0; slot = 0; sent = 0; need_rise = 0;
        out_rdy = 1'b1;
        for (int i = 0; i < 240; i++) begin
            in_val = (i < 200);
            hs = in_val && in_rdy;
            need_rise = in_rdy;
            if (hs) begin exp_q.push_back(in_msg); sent++; end
            rx = out_val && out_rdy;
            if (rx) begin
                if (exp_q.size() == 0 || out_msg != exp_q[0]) bad++;
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
            if (credit_o > 3'(DEPTH)) over++;
            step();
            if (need_rise && !rose) slot++;
            if (hs) in_msg = in_msg + 16'd1;
        end
        out_rdy = 1'b0;
        chk("R4", "ready outside a launch slot", slot, 0);
        chk("R6", "stream order/value mismatches", bad, 0);
        chk("R6", "stream messages undelivered", exp_q.size(), 0);
        chk("R5", "credit above depth during stream", over, 0);
        chk("R7", "credit after stream settles", credit_o, DEPTH);
        chk("R7", "stream kept moving (messages sent > 40)", int'(sent > 40), 1);
    endtask

    task automatic t_deadlock(input int lim);
        int k, early, at_lim;
        do_reset(1, lim);
        wait_up();
        in_val = 1'b1;
        while (credit_o != 0) step();
        in_val = 1'b0;
        k = 0; early = 0; at_lim = -1;
        while (k < lim + 1) begin
            step();
            if (rose) begin
                k++;
                if (k <= lim && deadlock_o) early++;
                if (k == lim + 1) at_lim = deadlock_o;
            end
        end
        chk("R8", $sformatf("deadlock early, limit=%0d", lim), early, 0);
        chk("R8", $sformatf("deadlock at rise limit+1, limit=%0d", lim), at_lim, 1);
        out_rdy = 1'b1;
        step();
        out_rdy = 1'b0;
        while (credit_o == 0) step();
        step();
        chk("R8", "deadlock cleared after credit return", deadlock_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual no finish expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_period(0);
        t_period(2);
        t_period(127);
        t_link_reset();
        t_fill_and_return();
        t_drain();
        t_latency();
        t_stream();
        t_deadlock(3);
        t_deadlock(0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule